// File: doc/BRIEF.md
# Red/Blue Normalized Color Thresholder

This block sits at the head of a sign-detection pipeline. It takes a stream of raster-ordered RGB pixels, one per clock, and reduces each one to a single foreground bit. For every pixel it forms a score from the larger of the red and blue channels, divided by a brightness sum in which green counts four times and a bias of 8 is added. The numerator is pre-scaled by 256 so that the integer quotient lands in an 8-bit gray range. A high score means the pixel is strongly red or blue and carries little green.

The gray score is compared against one of three preset thresholds. The caller picks the threshold for each pixel with a small select code. That code is captured together with the pixel, so changing it later does not affect pixels already in flight. The result leaves the block after a fixed pipeline delay, together with the gray value and the pixel's column and row, which are carried alongside the data. The output has no backpressure. A downstream region grouper must take one result per cycle.

Top module: `nrb_color_thresholder`

## Requirements
- R1: After reset is released, `in_ready` rises within three clock edges and then stays high. While it is high, a pixel is accepted on every edge where `in_valid` is 1, and consecutive accepted pixels appear on consecutive output cycles.
- R2: `out_gray` equals floor(256 * max(R,B) / (R + B + 4*G + 8)), clamped to 255. For any 8-bit input this value is at most 248.
- R3: A pixel captured at clock edge k appears with `out_valid` = 1 just after edge k+17, so its result is visible 18 edges after the capture edge counted inclusively. No `out_valid` occurs without a matching accepted pixel.
- R4: `out_x` and `out_y` return the column and row that were presented with the same pixel.
- R5: `out_fg` is 1 exactly when `out_gray` is greater than or equal to the selected threshold.
- R6: The `thr_sel` codes map as follows: 0 selects 64, 1 selects 96, 2 selects 128, and 3 also selects 128.
- R7: `thr_sel` is sampled on the edge that accepts the pixel. A later change to `thr_sel` does not alter that pixel's result.
- R8: While `out_valid` is 0, the outputs `out_fg`, `out_gray`, `out_x` and `out_y` are all 0. During reset and after it, `out_valid` stays 0 until a pixel has passed through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel present on the input |
| in_ready | output | 1 | Block can accept a pixel |
| in_r | input | 8 | Red channel |
| in_g | input | 8 | Green channel |
| in_b | input | 8 | Blue channel |
| in_x | input | 11 | Pixel column |
| in_y | input | 10 | Pixel row |
| thr_sel | input | 2 | Threshold select code |
| out_valid | output | 1 | Result present |
| out_fg | output | 1 | Foreground flag |
| out_gray | output | 8 | Normalized red/blue score |
| out_x | output | 11 | Column of the result |
| out_y | output | 10 | Row of the result |

## Verification
The assertions assume that the inputs carry known values whenever `in_valid` is high. They also assume that a pixel counts as delivered only on an edge where `in_ready` is also high. The in-flight count that bounds the pipeline depth is built on that assumption.

The bench holds `in_valid` low until it has seen `in_ready` high. It changes every input on the falling clock edge. It never leaves a channel undriven while `in_valid` is asserted.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
  // channel width of one colour component
  localparam int CH_W     = 8;
  // fixed shifts: numerator scale (x256) and green weight (x4)
  localparam int SCALE_SH = 8;
  localparam int GREEN_SH = 2;
  localparam int BIAS     = 8;
  localparam int SEL_W    = 2;
  localparam int GRAY_W   = 8;
  // derived widths
  localparam int NUM_W    = CH_W + SCALE_SH;          // scaled numerator
  localparam int DEN_W    = CH_W + GREEN_SH + 1;      // R+B+4G+8 fits
  localparam int REM_W    = DEN_W + 1;                // shifted remainder
  localparam int QW       = NUM_W;                    // quotient bits = stages

  typedef struct packed {
    logic [NUM_W-1:0] num;
    logic [DEN_W-1:0] den;
    logic [DEN_W-1:0] rem;
    logic [QW-1:0]    quo;
  } div_word_t;
endpackage

// File: rtl/nrb_front.sv
module nrb_front
  import nrb_pkg::*;
#(
  parameter int SIDE_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [CH_W-1:0]   r,
  input  logic [CH_W-1:0]   g,
  input  logic [CH_W-1:0]   b,
  input  logic [SIDE_W-1:0] side_in,
  output logic              vld_q,
  output div_word_t         word_q,
  output logic [SIDE_W-1:0] side_q
);
  logic [CH_W-1:0] peak;
  div_word_t       word_d;

  always_comb begin
    peak        = (r > b) ? r : b;
    word_d.num  = {peak, {SCALE_SH{1'b0}}};
    word_d.den  = DEN_W'(r) + DEN_W'(b) + {1'b0, g, {GREEN_SH{1'b0}}}
                + DEN_W'(BIAS);
    word_d.rem  = '0;
    word_d.quo  = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= acc;
  end

  // datapath flops: enabled by acceptance, no reset
  always_ff @(posedge clk) begin
    if (acc) begin
      word_q <= word_d;
      side_q <= side_in;
    end
  end
endmodule

// File: rtl/nrb_pipe_divider.sv
module nrb_pipe_divider
  import nrb_pkg::*;
#(
  parameter int SIDE_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld_in,
  input  div_word_t         word_in,
  input  logic [SIDE_W-1:0] side_in,
  output logic              vld_out,
  output logic [QW-1:0]     quo_out,
  output logic [SIDE_W-1:0] side_out
);
  // one restoring step per stage, MSB of the quotient first
  div_word_t         w_c    [0:QW-1];
  logic              v_c    [0:QW];
  logic [SIDE_W-1:0] s_c    [0:QW];

  assign w_c[0] = word_in;
  assign v_c[0] = vld_in;
  assign s_c[0] = side_in;

  for (genvar i = 0; i < QW; i++) begin : g_stage
    localparam int BIT = QW - 1 - i;
    div_word_t         nxt;
    logic [REM_W-1:0]  shifted;
    logic [REM_W-1:0]  den_ext;
    logic              v_r;
    logic [SIDE_W-1:0] s_r;

    always_comb begin
      nxt     = w_c[i];
      den_ext = REM_W'(w_c[i].den);
      shifted = {w_c[i].rem, w_c[i].num[BIT]};
      if (shifted >= den_ext) begin
        nxt.rem      = DEN_W'(shifted - den_ext);
        nxt.quo[BIT] = 1'b1;
      end else begin
        nxt.rem      = DEN_W'(shifted);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_r <= 1'b0;
      else        v_r <= v_c[i];
    end

    always_ff @(posedge clk) begin
      if (v_c[i]) s_r <= s_c[i];
    end

    assign v_c[i+1] = v_r;
    assign s_c[i+1] = s_r;

    if (i < QW - 1) begin : g_mid
      div_word_t w_r;
      always_ff @(posedge clk) begin
        if (v_c[i]) w_r <= nxt;
      end
      assign w_c[i+1] = w_r;
    end else begin : g_last
      logic [QW-1:0] q_r;
      always_ff @(posedge clk) begin
        if (v_c[i]) q_r <= nxt.quo;
      end
      assign quo_out = q_r;
    end
  end

  assign vld_out  = v_c[QW];
  assign side_out = s_c[QW];
endmodule

// File: rtl/nrb_thresh_out.sv
module nrb_thresh_out
  import nrb_pkg::*;
#(
  parameter int XW  = 11,
  parameter int YW  = 10,
  parameter int TH0 = 64,
  parameter int TH1 = 96,
  parameter int TH2 = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vld,
  input  logic [QW-1:0]     quo,
  input  logic [SEL_W-1:0]  sel,
  input  logic [XW-1:0]     x,
  input  logic [YW-1:0]     y,
  output logic              out_valid,
  output logic              out_fg,
  output logic [GRAY_W-1:0] out_gray,
  output logic [XW-1:0]     out_x,
  output logic [YW-1:0]     out_y
);
  localparam logic [QW-1:0] SAT = QW'((1 << GRAY_W) - 1);

  logic [GRAY_W-1:0] gray_sat, thr, gray_d;
  logic              fg_d;
  logic [XW-1:0]     x_d;
  logic [YW-1:0]     y_d;

  always_comb begin
    gray_sat = (quo > SAT) ? GRAY_W'(SAT) : quo[GRAY_W-1:0];
    case (sel)
      2'd0:    thr = GRAY_W'(TH0);
      2'd1:    thr = GRAY_W'(TH1);
      default: thr = GRAY_W'(TH2);
    endcase
    gray_d = vld ? gray_sat : '0;
    fg_d   = vld && (gray_sat >= thr);
    x_d    = vld ? x : '0;
    y_d    = vld ? y : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fg    <= 1'b0;
      out_gray  <= '0;
      out_x     <= '0;
      out_y     <= '0;
    end else begin
      out_valid <= vld;
      out_fg    <= fg_d;
      out_gray  <= gray_d;
      out_x     <= x_d;
      out_y     <= y_d;
    end
  end
endmodule

// File: rtl/nrb_color_thresholder.sv
module nrb_color_thresholder
  import nrb_pkg::*;
#(
  parameter int XW  = 11,
  parameter int YW  = 10,
  parameter int TH0 = 64,
  parameter int TH1 = 96,
  parameter int TH2 = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CH_W-1:0]   in_r,
  input  logic [CH_W-1:0]   in_g,
  input  logic [CH_W-1:0]   in_b,
  input  logic [XW-1:0]     in_x,
  input  logic [YW-1:0]     in_y,
  input  logic [SEL_W-1:0]  thr_sel,
  output logic              out_valid,
  output logic              out_fg,
  output logic [GRAY_W-1:0] out_gray,
  output logic [XW-1:0]     out_x,
  output logic [YW-1:0]     out_y
);
  localparam int SIDE_W = SEL_W + XW + YW;

  // reset: asserted asynchronously, released through two flops
  logic rs_meta, rs_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end
  assign in_ready = rs_sync;

  logic              acc;
  logic              f_vld, d_vld;
  div_word_t         f_word;
  logic [SIDE_W-1:0] f_side, d_side;
  logic [QW-1:0]     d_quo;

  assign acc = in_valid & in_ready;

  nrb_front #(.SIDE_W(SIDE_W)) u_front (
    .clk(clk), .rst_n(rs_sync), .acc(acc),
    .r(in_r), .g(in_g), .b(in_b),
    .side_in({thr_sel, in_x, in_y}),
    .vld_q(f_vld), .word_q(f_word), .side_q(f_side)
  );

  nrb_pipe_divider #(.SIDE_W(SIDE_W)) u_div (
    .clk(clk), .rst_n(rs_sync),
    .vld_in(f_vld), .word_in(f_word), .side_in(f_side),
    .vld_out(d_vld), .quo_out(d_quo), .side_out(d_side)
  );

  nrb_thresh_out #(.XW(XW), .YW(YW), .TH0(TH0), .TH1(TH1), .TH2(TH2)) u_out (
    .clk(clk), .rst_n(rs_sync),
    .vld(d_vld), .quo(d_quo),
    .sel(d_side[SIDE_W-1 -: SEL_W]),
    .x(d_side[YW +: XW]), .y(d_side[YW-1:0]),
    .out_valid(out_valid), .out_fg(out_fg), .out_gray(out_gray),
    .out_x(out_x), .out_y(out_y)
  );
endmodule

// File: rtl/nrb_thresh_chk.sv
module nrb_thresh_chk #(
  parameter int TH0 = 64,
  parameter int TH2 = 128,
  parameter int LAT = 18
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_fg,
  input logic [7:0] out_gray
);
  localparam int CW = $clog2(LAT + 2) + 1;
  logic [CW-1:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + CW'(in_valid && in_ready) - CW'(out_valid);
  end

  // R1: once ready, it stays ready
  a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> in_ready);

  // R2: score bounded by 256*255/263
  a_r2_gray_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_gray <= 8'd248);

  // R3: pipeline never holds more than its depth, and no output without a pixel
  a_r3_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CW'(LAT));
  a_r3_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != '0);

  // R5: below the lowest preset never foreground, at the highest always
  a_r5_below_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_gray < 8'(TH0)) |-> !out_fg);
  a_r5_above_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_gray >= 8'(TH2)) |-> out_fg);

  // R8: quiet outputs when no result
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_fg && out_gray == 8'd0));
endmodule

bind nrb_color_thresholder nrb_thresh_chk #(
  .TH0(TH0), .TH2(TH2), .LAT(nrb_pkg::QW + 2)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_fg(out_fg), .out_gray(out_gray)
);

// File: tb/tb_nrb_color_thresholder.sv
`timescale 1ns/1ps
module tb_nrb_color_thresholder;
  localparam int NV = 13;
  // entry: {r, g, b, sel}
  localparam logic [25:0] VEC [NV] = '{
    {8'd0,   8'd0,   8'd0,   2'd0},
    {8'd255, 8'd0,   8'd0,   2'd0},
    {8'd0,   8'd0,   8'd255, 2'd1},
    {8'd255, 8'd0,   8'd255, 2'd2},
    {8'd255, 8'd255, 8'd255, 2'd0},
    {8'd48,  8'd10,  8'd0,   2'd2},
    {8'd48,  8'd10,  8'd1,   2'd2},
    {8'd40,  8'd28,  8'd0,   2'd0},
    {8'd40,  8'd28,  8'd0,   2'd1},
    {8'd48,  8'd10,  8'd0,   2'd3},
    {8'd47,  8'd10,  8'd0,   2'd3},
    {8'd0,   8'd200, 8'd30,  2'd1},
    {8'd200, 8'd5,   8'd100, 2'd1}
  };

  logic clk, rst_n, in_valid, in_ready, out_valid, out_fg;
  logic [7:0] in_r, in_g, in_b, out_gray;
  logic [10:0] in_x, out_x;
  logic [9:0] in_y, out_y;
  logic [1:0] thr_sel;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  nrb_color_thresholder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .in_x(in_x), .in_y(in_y),
    .thr_sel(thr_sel), .out_valid(out_valid), .out_fg(out_fg),
    .out_gray(out_gray), .out_x(out_x), .out_y(out_y)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_gray(int r, int g, int b);
    int m, q;
    m = (r > b) ? r : b;
    q = (m * 256) / (r + b + 4 * g + 8);
    return (q > 255) ? 255 : q;
  endfunction

  function automatic int exp_thr(int s);
    return (s == 0) ? 64 : (s == 1) ? 96 : 128;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int o_gray [32], o_fg [32], o_x [32], o_y [32], o_cyc [32];
  int nobs;

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_r = 0; in_g = 0; in_b = 0;
    in_x = 0; in_y = 0; thr_sel = 0;
    repeat (3) @(negedge clk);
    // R8 / R1 reset state
    chk("R8 reset out_valid", out_valid, 0);
    chk("R8 reset out_gray", out_gray, 0);
    chk("R1 reset in_ready", in_ready, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 ready after release", in_ready, 1);
    chk("R8 idle after reset", out_valid, 0);

    // R3 latency with a single pixel
    begin
      int n = 0;
      in_valid = 1; in_r = 255; in_g = 0; in_b = 0; in_x = 5; in_y = 9; thr_sel = 0;
      @(posedge clk); n = 1;
      @(negedge clk); in_valid = 0;
      while (!out_valid && n < 40) begin
        @(posedge clk); n++;
        @(negedge clk);
      end
      chk("R3 latency edges", n, 18);
      chk("R2 single gray", out_gray, exp_gray(255, 0, 0));
      chk("R4 single x", out_x, 5);
      chk("R4 single y", out_y, 9);
      @(negedge clk);
      chk("R8 quiet after result valid", out_valid, 0);
      chk("R8 quiet after result fg", out_fg, 0);
      chk("R8 quiet after result x", out_x, 0);
    end

    // vector stream, back to back
    nobs = 0;
    fork
      begin
        for (int i = 0; i < NV; i++) begin
          in_valid = 1;
          {in_r, in_g, in_b, thr_sel} = VEC[i];
          in_x = 11'(i); in_y = 10'(100 + i);
          @(negedge clk);
        end
        in_valid = 0;
      end
      begin
        for (int k = 0; k < 50; k++) begin
          @(negedge clk);
          if (out_valid && nobs < 32) begin
            o_gray[nobs] = out_gray; o_fg[nobs] = out_fg;
            o_x[nobs] = out_x; o_y[nobs] = out_y; o_cyc[nobs] = cyc;
            nobs++;
          end
        end
      end
    join
    chk("R1 stream count", nobs, NV);
    for (int i = 0; i < NV && i < nobs; i++) begin
      int r, g, b, s, eg;
      r = VEC[i][25:18]; g = VEC[i][17:10]; b = VEC[i][9:2]; s = VEC[i][1:0];
      eg = exp_gray(r, g, b);
      chk("R2 gray", o_gray[i], eg);
      chk("R5 R6 fg", o_fg[i], (eg >= exp_thr(s)) ? 1 : 0);
      chk("R4 x", o_x[i], i);
      chk("R4 y", o_y[i], 100 + i);
      chk("R1 back-to-back", o_cyc[i] - o_cyc[0], i);
    end

    // R7: select changes after acceptance
    begin
      int n = 0;
      in_valid = 1; in_r = 40; in_g = 28; in_b = 0; in_x = 3; in_y = 4; thr_sel = 0;
      @(negedge clk);
      in_valid = 0; thr_sel = 2;
      while (!out_valid && n < 40) begin
        @(negedge clk); n++;
      end
      chk("R7 gray", out_gray, 64);
      chk("R7 select held with pixel", out_fg, 1);
    end

    // R8: long idle gap stays quiet
    begin
      int seen = 0;
      repeat (25) begin
        @(negedge clk);
        if (out_valid || out_fg || out_gray != 0) seen++;
      end
      chk("R8 idle gap", seen, 0);
      chk("R1 ready still high", in_ready, 1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule